// File: doc/BRIEF.md
# Bit Toggle Activity Counter

The block estimates switching activity on one monitored data port, such as a register file read or write port. Each time it samples the port, it XORs the port value with the value it sampled last. It then adds the number of differing bits to a running total. The total is a Hamming-distance count that a power model can scale into a switching factor. Mapping that count to power values is left to software.

Sampling is qualified by a valid input. It can be thinned to every 2^k-th valid beat to save energy in the counting logic. The count is not rescaled when sampling is thinned. The population count runs through a registered adder tree, and a saturating accumulator holds the total. A clear input zeroes the total and loads the current port value as the new reference, so the first sample after a clear does not see a false transition.

Top module: `toggle_activity_counter`

## Requirements
- R1: While reset is asserted and after it is released, `count_o` reads zero until a sampled beat reaches it.
- R2: Each sampled beat adds the number of set bits in (`data_i` XOR the previously sampled value). Alternating all-ones and all-zeros beats at full rate add DATA_W per beat. Repeating a value adds zero.
- R3: A cycle with `valid_i` low samples nothing. It changes neither the count nor the stored previous value, whatever `data_i` carries.
- R4: With `rate_i` = k (0 to 7), only valid beats whose index since reset or clear is a multiple of 2^k are sampled. The first valid beat after reset or clear is always sampled. Counts are not multiplied by 2^k.
- R5: A beat sampled at rising edge N is visible on `count_o` after rising edge N+1, and not after edge N.
- R6: With `clear_i` high at an edge, `count_o` is zero after that edge. The `data_i` present at that edge becomes the stored previous value even if `valid_i` is low. The beat index restarts at zero. A sample still in the adder pipeline is discarded. A valid beat in the same cycle is not sampled.
- R7: The accumulator saturates at 2^ACC_W-1 and holds there until cleared.
- R8: After reset the stored previous value is all zeros, so the first sample adds the population count of `data_i` itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Monitored port value |
| valid_i | input | 1 | Port value qualifier |
| rate_i | input | 3 | Decimation exponent k, one sample per 2^k valid beats |
| clear_i | input | 1 | Zero the count, reload the reference, restart decimation |
| count_o | output | ACC_W | Accumulated toggle count |

## Verification
The assertions assume that `rate_i` is held steady between clears. They also assume that the per-cycle increase of the count never exceeds DATA_W, which holds only because each sample is a single XOR of two DATA_W-bit words. The stimulus changes `rate_i` only in the same cycle as a pulse on `clear_i`, and it drives `clear_i` as single-cycle pulses. A second instance with an 8-bit accumulator is driven from the same inputs so that saturation is reached within the run.

// File: rtl/toggle_pkg.sv
package toggle_pkg;
  localparam int unsigned RATE_W = 3;
  typedef logic [RATE_W-1:0] rate_t;

  function automatic int unsigned cnt_width(input int unsigned w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/toggle_decimator.sv
module toggle_decimator
  import toggle_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  logic  clear_i,
  input  rate_t rate_i,
  output logic  fire_o
);
  localparam int unsigned MAX_K = (1 << RATE_W) - 1;

  logic [MAX_K-1:0] beat_q;
  logic [MAX_K-1:0] mask;

  always_comb begin
    for (int b = 0; b < MAX_K; b++) mask[b] = (b < int'(rate_i));
  end

  assign fire_o = valid_i & ~clear_i & ((beat_q & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (clear_i) beat_q <= '0;
    else if (valid_i) beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/toggle_popcount.sv
module toggle_popcount
  import toggle_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = cnt_width(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_vld_i,
  input  logic              flush_i,
  input  logic [DATA_W-1:0] bits_i,
  output logic              cnt_vld_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned LEAVES = 1 << $clog2(DATA_W);
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  // heap layout: node i sums nodes 2i+1 and 2i+2, leaves at the tail
  logic [CNT_W-1:0] node [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < DATA_W) begin : g_bit
      assign node[LEAVES-1+j] = CNT_W'(bits_i[j]);
    end else begin : g_pad
      assign node[LEAVES-1+j] = '0;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_sum
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_vld_o <= 1'b0;
      cnt_o     <= '0;
    end else begin
      cnt_vld_o <= in_vld_i & ~flush_i;
      if (in_vld_i) cnt_o <= node[0];
    end
  end
endmodule

// File: rtl/toggle_accum.sv
module toggle_accum #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             add_vld_i,
  input  logic [CNT_W-1:0] add_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc_o} + (ACC_W+1)'(add_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_o <= '0;
    else if (clear_i)   acc_o <= '0;
    else if (add_vld_i) acc_o <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  end
endmodule

// File: rtl/toggle_activity_counter.sv
module toggle_activity_counter
  import toggle_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ACC_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  rate_t             rate_i,
  input  logic              clear_i,
  output logic [ACC_W-1:0]  count_o
);
  localparam int unsigned CNT_W = cnt_width(DATA_W);

  logic              fire;
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] diff;
  logic              pc_vld;
  logic [CNT_W-1:0]  pc_val;

  toggle_decimator u_decim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .clear_i (clear_i),
    .rate_i  (rate_i),
    .fire_o  (fire)
  );

  // clear reloads the reference so the next sample sees no false toggles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              prev_q <= '0;
    else if (clear_i || fire) prev_q <= data_i;
  end

  assign diff = data_i ^ prev_q;

  toggle_popcount #(.DATA_W(DATA_W)) u_pop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (fire),
    .flush_i   (clear_i),
    .bits_i    (diff),
    .cnt_vld_o (pc_vld),
    .cnt_o     (pc_val)
  );

  toggle_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .add_vld_i (pc_vld),
    .add_i     (pc_val),
    .acc_o     (count_o)
  );
endmodule

// File: rtl/toggle_activity_chk.sv
module toggle_activity_chk
  import toggle_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ACC_W  = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             clear_i,
  input rate_t            rate_i,
  input logic [ACC_W-1:0] count_o,
  input logic             pc_vld_i
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0); // R6

  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !pc_vld_i); // R6

  AST_NO_SAMPLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !pc_vld_i); // R3

  AST_HOLD_NO_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_vld_i && !clear_i) |=> $stable(count_o)); // R3

  AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && rate_i == '0) |=> pc_vld_i); // R4

  AST_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> count_o >= $past(count_o)); // R2

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (count_o - $past(count_o)) <= ACC_W'(DATA_W)); // R2

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '1 && !clear_i) |=> count_o == '1); // R7
endmodule

bind toggle_activity_counter toggle_activity_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .clear_i  (clear_i),
  .rate_i   (rate_i),
  .count_o  (count_o),
  .pc_vld_i (pc_vld)
);

// File: tb/toggle_activity_counter_tb.sv
module toggle_activity_counter_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data = '0;
  logic          valid = 1'b0;
  logic [2:0]    rate = '0;
  logic          clear = 1'b0;
  logic [39:0]   count;
  logic [7:0]    count_s;

  int tests = 0;
  int fails = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  toggle_activity_counter #(.DATA_W(DW), .ACC_W(40)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
    .rate_i(rate), .clear_i(clear), .count_o(count));

  toggle_activity_counter #(.DATA_W(DW), .ACC_W(8)) u_sat (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
    .rate_i(rate), .clear_i(clear), .count_o(count_s));

  // behavioural reference
  logic [DW-1:0] m_prev = '0;
  int            m_beat = 0;
  bit            m_pend = 0;
  int            m_pcnt = 0;
  longint        m_acc  = 0;
  longint        m_acc8 = 0;
  localparam longint MAX40 = (64'sd1 <<< 40) - 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_beat = 0; m_pend = 0; m_acc = 0; m_acc8 = 0;
    end else if (clear) begin
      m_acc = 0; m_acc8 = 0; m_prev = data; m_beat = 0; m_pend = 0;
    end else begin
      bit fire;
      if (m_pend) begin
        m_acc  = (m_acc + m_pcnt > MAX40) ? MAX40 : m_acc + m_pcnt;
        m_acc8 = (m_acc8 + m_pcnt > 255) ? 255 : m_acc8 + m_pcnt;
      end
      fire = valid && ((m_beat % (1 << rate)) == 0);
      if (valid) m_beat = (m_beat + 1) % 128;
      m_pend = fire;
      m_pcnt = $countones(data ^ m_prev);
      if (fire) m_prev = data;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check({phase, " model"}, longint'(count), m_acc);
      check({phase, " model sat"}, longint'(count_s), m_acc8);
    end
  end

  task automatic step(input logic [DW-1:0] d, input logic v, input logic c);
    @(negedge clk);
    data = d; valid = v; clear = c;
  endtask

  task automatic do_clear(input logic [DW-1:0] d, input logic [2:0] k);
    @(negedge clk);
    data = d; valid = 1'b1; clear = 1'b1; rate = k;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(data, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint base;
    repeat (3) @(negedge clk);
    check("R1 in reset", longint'(count), 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 after reset", longint'(count), 0);

    // R8: reference is zero after reset
    phase = "R8";
    step(32'hF0F0_000F, 1'b1, 1'b0);
    idle(2);
    check("R8 first sample", longint'(count), 12);

    // R2: alternating and repeated values
    phase = "R2";
    do_clear(32'h0, 3'd0);
    step(32'hFFFF_FFFF, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step((i % 2) ? 32'hFFFF_FFFF : 32'h0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(32'h0, 1'b1, 1'b0);
    idle(2);
    check("R2 alternating", longint'(count), 6 * DW);
    for (int i = 0; i < 20; i++) step($urandom, 1'b1, 1'b0);
    idle(2);

    // R3: invalid cycles leave count and reference alone
    phase = "R3";
    do_clear(32'h1234_5678, 3'd0);
    step(32'h1234_5678, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step($urandom, 1'b0, 1'b0);
    check("R3 idle count", longint'(count), 0);
    step(32'h1234_5678, 1'b1, 1'b0);
    idle(2);
    check("R3 reference kept", longint'(count), 0);

    // R5: two-edge latency
    phase = "R5";
    base = longint'(count);
    step(32'h1234_567F, 1'b1, 1'b0);
    step(data, 1'b0, 1'b0);
    check("R5 not after one edge", longint'(count), base);
    step(data, 1'b0, 1'b0);
    check("R5 after two edges", longint'(count), base + 3);

    // R6: clear reloads reference even with valid low, drops in-flight sample
    phase = "R6";
    step(32'hAAAA_5555, 1'b1, 1'b0);
    @(negedge clk); data = 32'hCAFE_0000; valid = 1'b0; clear = 1'b1;
    step(32'hCAFE_0000, 1'b1, 1'b0);
    check("R6 zero after clear", longint'(count), 0);
    step(32'hCAFE_0001, 1'b1, 1'b0);
    idle(2);
    check("R6 reference from clear", longint'(count), 1);

    // R4: decimation, first beat after clear sampled, no rescale
    phase = "R4";
    do_clear(32'h0, 3'd1);
    step(32'hFFFF_FFFF, 1'b1, 1'b0);
    for (int i = 1; i < 8; i++) step((i % 2) ? 32'h0 : 32'hFFFF_FFFF, 1'b1, 1'b0);
    idle(2);
    check("R4 rate 1", longint'(count), DW);
    do_clear(32'h0, 3'd2);
    step(32'h0000_00FF, 1'b1, 1'b0);
    step(32'hFFFF_FFFF, 1'b1, 1'b0);
    step(32'hFFFF_FFFF, 1'b0, 1'b0);
    step(32'hFFFF_FFFF, 1'b1, 1'b0);
    step(32'hFFFF_FFFF, 1'b1, 1'b0);
    step(32'h0000_0000, 1'b1, 1'b0);
    idle(2);
    check("R4 rate 2 gaps", longint'(count), 8 + 8);
    for (int k = 0; k < 8; k++) begin
      do_clear($urandom, 3'(k));
      for (int i = 0; i < 300; i++) step($urandom, 1'($urandom), 1'b0);
      idle(2);
    end

    // R7: saturation on the narrow instance
    phase = "R7";
    do_clear(32'h0, 3'd0);
    for (int i = 0; i < 12; i++) step((i % 2) ? 32'h0 : 32'hFFFF_FFFF, 1'b1, 1'b0);
    idle(2);
    check("R7 saturated", longint'(count_s), 255);
    check("R7 wide unsaturated", longint'(count), 12 * DW);
    for (int i = 0; i < 4; i++) step((i % 2) ? 32'h0 : 32'hFFFF_FFFF, 1'b1, 1'b0);
    idle(2);
    check("R7 held", longint'(count_s), 255);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule